// File: doc/BRIEF.md
# Transposed Three-Tap FIR Filter with Two-Stage Multipliers

This block filters a stream of signed fixed-point samples with three fixed coefficients: out(n) = a·x(n) + b·x(n−1) + c·x(n−2). It uses the transposed arrangement. Each accepted sample goes to all three coefficient multipliers in the same cycle. The delay registers sit on the accumulation chain between the adders, not on the incoming samples.

Each multiplier is cut into two pipelined halves. The first half forms the product of the sample with the low half of the coefficient bits and registers it together with the sample. The second half adds the high-half product, shifted into place, and feeds the sum straight into the chain adder. The longest path is therefore about half a multiply plus one add.

The interface takes one sample per clock with a valid flag and returns one full-precision result per clock with a valid flag. Cycles without a valid input are gaps. They do not advance the filter history.

Top module: `fir_tf_split`

## Requirements
- R1: For each accepted sample x(n), out_data equals a·x(n) + b·x(n−1) + c·x(n−2), where x(n−1) and x(n−2) are the two previously accepted samples. The result is exact, signed two's complement, ACC_W bits wide. The coefficients are packed in COEFS with a in bits [COEF_W-1:0], b in the next COEF_W bits and c in the top COEF_W bits.
- R2: A sample accepted in cycle t (in_valid high at the clock edge ending cycle t) produces its result in cycle t+2, so it is visible after the second rising edge.
- R3: out_valid is high in cycle t+2 exactly when in_valid was high in cycle t. It is low otherwise.
- R4: When in_valid is low, in_data has no effect. The filter history does not advance, and the next valid sample is combined with the last two valid samples across any gap.
- R5: While out_valid is low, out_data keeps the last value it held.
- R6: A synchronous active-high reset clears out_valid, clears out_data to zero and clears the history. The first two results after reset therefore treat the missing earlier samples as zero.
- R7: Products are exact for extreme operands, including the most negative input (−32768) multiplied by the most negative coefficient (−32768 with the default 16-bit widths).
- R8: Valid samples on every consecutive cycle give one result per cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when in_data carries a sample |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | High when out_data carries a new result |
| out_data | output | ACC_W | Signed full-precision filter result |

## Verification
Every result is due exactly two rising edges after its sample is accepted. The first edge loads the first multiplier half. The second edge loads the chain register that drives out_data. The bench drives inputs on the falling edge and keeps a queue of expected entries, one per driven cycle. It compares the entry pushed two falling edges earlier with out_valid and out_data. During gap cycles it compares out_data with the last expected valid result, or with zero right after reset.

// File: rtl/fir_tf_pkg.sv
`timescale 1ns/1ps
package fir_tf_pkg;

    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_COEF_W = 16;
    localparam int unsigned DEF_TAPS   = 3;

    // tap 0 (current sample) in the low bits; -32768, 23170, -1
    localparam logic [DEF_TAPS*DEF_COEF_W-1:0] DEF_COEFS =
        {16'hFFFF, 16'h5A82, 16'h8000};

    // width of an exact product of two signed operands
    function automatic int unsigned prod_width(int unsigned dw, int unsigned cw);
        return dw + cw;
    endfunction

    // product width plus growth for summing n products
    function automatic int unsigned acc_width(int unsigned dw, int unsigned cw,
                                              int unsigned n);
        return dw + cw + $clog2(n);
    endfunction

    // number of coefficient bits handled in the first multiplier half
    function automatic int unsigned low_split(int unsigned cw);
        return cw / 2;
    endfunction

endpackage

// File: rtl/tf_split_mult.sv
`timescale 1ns/1ps
module tf_split_mult
    import fir_tf_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned COEF_W = DEF_COEF_W,
    parameter logic signed [COEF_W-1:0] COEF = '0,
    parameter int unsigned PROD_W = prod_width(DATA_W, COEF_W)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     half_valid,
    output logic signed [PROD_W-1:0] product
);
    localparam int unsigned LO_W  = low_split(COEF_W);
    localparam int unsigned HI_W  = COEF_W - LO_W;
    localparam int unsigned LOP_W = DATA_W + LO_W + 1;

    localparam logic [LO_W-1:0]        COEF_LO = COEF[LO_W-1:0];
    localparam logic signed [HI_W-1:0] COEF_HI = COEF[COEF_W-1:LO_W];

    typedef struct packed {
        logic                     v;
        logic signed [DATA_W-1:0] x;
        logic signed [LOP_W-1:0]  plo;
    } half_t;

    half_t                    st_q;
    logic signed [LOP_W-1:0]  x_lo_ext;
    logic signed [LOP_W-1:0]  c_lo_ext;
    logic signed [LOP_W-1:0]  lo_mul;
    logic signed [PROD_W-1:0] x_hi_ext;
    logic signed [PROD_W-1:0] c_hi_ext;
    logic signed [PROD_W-1:0] hi_mul;
    logic signed [PROD_W-1:0] plo_ext;

    // first half: sample times unsigned low coefficient bits
    always_comb begin
        x_lo_ext = {{(LOP_W-DATA_W){in_data[DATA_W-1]}}, in_data};
        c_lo_ext = {{(LOP_W-LO_W){1'b0}}, COEF_LO};
        lo_mul   = x_lo_ext * c_lo_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.v   <= in_valid;
            st_q.x   <= in_data;
            st_q.plo <= lo_mul;
        end
    end

    // second half: signed high coefficient bits, weighted by 2^LO_W
    always_comb begin
        x_hi_ext = {{(PROD_W-DATA_W){st_q.x[DATA_W-1]}}, st_q.x};
        c_hi_ext = {{(PROD_W-HI_W){COEF_HI[HI_W-1]}}, COEF_HI};
        hi_mul   = x_hi_ext * c_hi_ext;
        plo_ext  = {{(PROD_W-LOP_W){st_q.plo[LOP_W-1]}}, st_q.plo};
        product  = (hi_mul <<< LO_W) + plo_ext;
    end

    assign half_valid = st_q.v;

    // R7: the two halves together give the exact full product
    a_r7_exact_product: assert property (@(posedge clk) disable iff (rst)
        half_valid |-> (product == $past(in_data) * COEF));

endmodule

// File: rtl/tf_accum_chain.sv
`timescale 1ns/1ps
module tf_accum_chain #(
    parameter int unsigned NTAPS  = 3,
    parameter int unsigned PROD_W = 32,
    parameter int unsigned ACC_W  = 34
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          step,
    input  logic [NTAPS-1:0][PROD_W-1:0]  prods,
    output logic                          out_valid,
    output logic signed [ACC_W-1:0]       out_data
);
    logic [NTAPS-1:0][ACC_W-1:0] acc_q;
    logic                        vld_q;

    // acc_q[0] is the output; acc_q[k] holds the partial sum that
    // tap k-1 adds one accepted sample later
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        logic [ACC_W-1:0] p_ext;
        assign p_ext = {{(ACC_W-PROD_W){prods[k][PROD_W-1]}}, prods[k]};
        if (k == NTAPS - 1) begin : g_last
            always_ff @(posedge clk) begin
                if (rst)       acc_q[k] <= '0;
                else if (step) acc_q[k] <= p_ext;
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst)       acc_q[k] <= '0;
                else if (step) acc_q[k] <= p_ext + acc_q[k+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= step;
    end

    assign out_valid = vld_q;
    assign out_data  = $signed(acc_q[0]);

    // R5: output keeps its value through a cycle with no product step
    a_r5_hold_on_gap: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(out_data));

endmodule

// File: rtl/fir_tf_split.sv
`timescale 1ns/1ps
module fir_tf_split
    import fir_tf_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned COEF_W = DEF_COEF_W,
    parameter int unsigned NTAPS  = DEF_TAPS,
    parameter logic [NTAPS*COEF_W-1:0] COEFS = DEF_COEFS,
    parameter int unsigned ACC_W  = acc_width(DATA_W, COEF_W, NTAPS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_data
);
    localparam int unsigned PROD_W = prod_width(DATA_W, COEF_W);

    logic [NTAPS-1:0]             half_vld;
    logic [NTAPS-1:0][PROD_W-1:0] prods;
    logic                         step;

    // broadcast: every multiplier sees the same sample in the same cycle
    for (genvar k = 0; k < NTAPS; k++) begin : g_mul
        logic signed [PROD_W-1:0] p;
        tf_split_mult #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .COEF   (COEFS[k*COEF_W +: COEF_W]),
            .PROD_W (PROD_W)
        ) u_mul (
            .clk        (clk),
            .rst        (rst),
            .in_valid   (in_valid),
            .in_data    (in_data),
            .half_valid (half_vld[k]),
            .product    (p)
        );
        assign prods[k] = p;
    end

    assign step = &half_vld;

    tf_accum_chain #(
        .NTAPS  (NTAPS),
        .PROD_W (PROD_W),
        .ACC_W  (ACC_W)
    ) u_chain (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .prods     (prods),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R2 / R3: a result is due two edges after its sample
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    // R3 / R4: no sample means no result and an unchanged output
    a_r4_gap_no_effect: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 (!out_valid && $stable(out_data)));

    // R6: reset clears the output side
    a_r6_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R8: all multiplier halves stay in step
    a_r8_taps_aligned: assert property (@(posedge clk) disable iff (rst)
        (half_vld == '0) || (&half_vld));

endmodule

// File: tb/fir_tf_split_bench.sv
`timescale 1ns/1ps
module fir_tf_split_bench;

    localparam int unsigned DW = 16;
    localparam int unsigned CW = 16;
    localparam int unsigned AW = 34;
    localparam logic [3*CW-1:0] COEFS = {16'hFFFF, 16'h5A82, 16'h8000};
    localparam longint KA = -32768;
    localparam longint KB = 23170;
    localparam longint KC = -1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic                 out_valid;
    logic signed [AW-1:0] out_data;

    fir_tf_split #(
        .DATA_W(DW), .COEF_W(CW), .NTAPS(3), .COEFS(COEFS), .ACC_W(AW)
    ) u_fir_tf_split (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #2 clk = ~clk;

    typedef struct { bit v; longint d; } exp_t;
    exp_t   pend[$];
    longint h1, h2, held;
    int     n_chk = 0, n_bad = 0;
    bit     done = 1'b0;

    task automatic check(string req, bit ok, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        h1 = 0; h2 = 0; held = 0;
        pend.delete();
    endtask

    // one cycle: compare the entry due now, drive new input, advance
    task automatic cycle(bit v, longint d, string req);
        exp_t e;
        if (pend.size() == 2) begin
            e = pend.pop_front();
            check({req, " R3 valid"}, out_valid == e.v, out_valid, e.v);
            if (e.v) begin
                check({req, " R1 R2 data"}, longint'(out_data) == e.d,
                      longint'(out_data), e.d);
                held = e.d;
            end else begin
                check({req, " R4 R5 hold"}, longint'(out_data) == held,
                      longint'(out_data), held);
            end
        end
        in_valid = v;
        in_data  = DW'(d);
        e.v = v;
        e.d = 0;
        if (v) begin
            e.d = KA * d + KB * h1 + KC * h2;
            h2 = h1;
            h1 = d;
        end
        pend.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 reset valid", out_valid == 1'b0, out_valid, 0);
        check("R6 reset data", out_data == '0, longint'(out_data), 0);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic flush(string req);
        for (int i = 0; i < 3; i++) cycle(1'b0, 16'h5555, req);
    endtask

    initial begin
        model_clear();
        @(negedge clk);
        do_reset();

        // R6: first results after reset see zero history; R2 impulse
        cycle(1'b1, 1, "R6 impulse");
        for (int i = 0; i < 4; i++) cycle(1'b1, 0, "R2 impulse tail");
        flush("R5 idle");

        // R4: gaps with garbage data between valid samples
        cycle(1'b1, 100, "R4 gap");
        cycle(1'b0, -7777, "R4 gap");
        cycle(1'b0, 12345, "R4 gap");
        cycle(1'b1, -200, "R4 gap");
        cycle(1'b0, 32767, "R4 gap");
        cycle(1'b1, 300, "R4 gap");
        flush("R4 gap");

        // R7: extreme operands, R8 back-to-back
        for (int i = 0; i < 4; i++) cycle(1'b1, -32768, "R7 min");
        for (int i = 0; i < 4; i++) cycle(1'b1, 32767, "R7 max");
        for (int i = 0; i < 6; i++)
            cycle(1'b1, (i % 2) ? -32768 : 32767, "R7 R8 alternate");
        flush("R7 tail");

        // R6: mid-stream reset drops history
        cycle(1'b1, 5000, "R6 pre");
        cycle(1'b1, -6000, "R6 pre");
        do_reset();
        cycle(1'b1, 1, "R6 after");
        cycle(1'b1, 0, "R6 after");
        cycle(1'b1, 0, "R6 after");
        flush("R6 tail");

        // R1 R8: random stream, first continuous then with random gaps
        for (int i = 0; i < 800; i++)
            cycle(1'b1, longint'($signed(16'($urandom))), "R1 R8 random");
        for (int i = 0; i < 1500; i++)
            cycle(($urandom % 4) != 0,
                  longint'($signed(16'($urandom))), "R1 R4 random gaps");
        flush("R1 tail");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule